// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic logic unit. It is built from one-bit slices repeated across the operand width. Two operands and a three-bit operation code go in. A result word, a zero flag and a signed-overflow flag come out in the same cycle. The operations are bitwise AND, bitwise OR, addition, subtraction and a signed set-on-less-than. The block holds no state and has no clock.

The upper bit of the operation code drives two things at once: it inverts every bit of the second operand in each slice, and it sets the carry into slice 0. Subtraction is therefore addition of the two's complement. For set-on-less-than, the sum bit of the top slice during `a - b` is routed back to the less-than input of slice 0. The less-than inputs of all other slices are tied low. The zero flag reduces the whole result word, so an equality test is a subtraction followed by a check of the flag. Overflow is a flag only and raises no trap.

Operation-code states (decoded, no sequencing):
- `OP_AND` (000)
- `OP_OR` (001)
- `OP_ADD` (010)
- `OP_SUB` (110)
- `OP_SLT` (111)
- Undefined codes (011, 100, 101)

Top module: `bitslice_alu`

## Requirements
- R1: With op_in = 3'b000 the result is the bitwise AND of a_in and b_in.
- R2: With op_in = 3'b001 the result is the bitwise OR of a_in and b_in.
- R3: With op_in = 3'b010 the result is a_in + b_in modulo 2^WIDTH.
- R4: With op_in = 3'b110 the result is a_in - b_in modulo 2^WIDTH, formed as a_in + ~b_in + 1.
- R5: With op_in = 3'b111, result bit 0 equals bit WIDTH-1 of (a_in - b_in) taken raw, with no overflow correction. All other result bits are 0.
- R6: zero_o is 1 exactly when every bit of result_o is 0, for every op code.
- R7: With op_in = 3'b010, ovf_o is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R8: With op_in = 3'b110, ovf_o is 1 exactly when the operand sign bits differ and the difference's sign bit differs from a_in's sign bit.
- R9: ovf_o is 0 for op codes 000, 001 and 111, whatever the operands.
- R10: The undefined op codes 3'b011, 3'b100 and 3'b101 give result_o = 0, zero_o = 1 and ovf_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| op_in | input | 3 | Operation code |
| result_o | output | WIDTH | Result word |
| zero_o | output | 1 | High when result_o is all zeros |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The logic operations use complementary and overlapping bit patterns, so that a swap of AND and OR shows up.

Addition and subtraction cover five cases:
- plain values
- carries that ripple through every slice
- wrap-around at all ones
- the four sign combinations that overflow
- neighbouring sign combinations that must not overflow

Set-on-less-than uses pairs on both sides of zero and equal operands. It also uses the extreme pair where the raw sign disagrees with true ordering, which shows that no overflow correction is applied.

Every undefined code is driven with non-zero operands. This shows that these codes neither leak a slice result nor raise the flag.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Operation codes; bit 2 doubles as operand invert and carry-in.
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    // Per-slice output multiplexer select.
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    localparam int OP_BITS = 3;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [OP_BITS-1:0] op_in,
    output logic               inv_o,
    output slice_sel_e         sel_o,
    output logic               valid_o,
    output logic               arith_o
);

    always_comb begin
        inv_o   = op_in[2];
        sel_o   = slice_sel_e'(op_in[1:0]);
        valid_o = 1'b0;
        arith_o = 1'b0;
        unique case (op_in)
            OP_AND, OP_OR, OP_SLT: valid_o = 1'b1;
            OP_ADD, OP_SUB: begin
                valid_o = 1'b1;
                arith_o = 1'b1;
            end
            default: valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       inv_i,
    input  logic       cin_i,
    input  logic       less_i,
    input  slice_sel_e sel_i,
    output logic       res_o,
    output logic       sum_o,
    output logic       cout_o
);

    logic b_eff;

    always_comb begin
        b_eff  = b_i ^ inv_i;
        sum_o  = a_i ^ b_eff ^ cin_i;
        cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
        unique case (sel_i)
            SEL_AND:  res_o = a_i & b_eff;
            SEL_OR:   res_o = a_i | b_eff;
            SEL_SUM:  res_o = sum_o;
            SEL_LESS: res_o = less_i;
            default:  res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_i,
    output logic             zero_o
);

    assign zero_o = ~(|word_i);

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]   a_in,
    input  logic [WIDTH-1:0]   b_in,
    input  logic [OP_BITS-1:0] op_in,
    output logic [WIDTH-1:0]   result_o,
    output logic               zero_o,
    output logic               ovf_o
);

    localparam int MSB = WIDTH - 1;

    logic             inv;
    slice_sel_e       sel;
    logic             op_valid;
    logic             op_arith;
    logic [WIDTH-1:0] res_v;
    logic [WIDTH-1:0] sum_v;
    logic             set_bit;
    logic             msb_cin;
    logic             msb_cout;

    alu_op_decode u_dec (
        .op_in  (op_in),
        .inv_o  (inv),
        .sel_o  (sel),
        .valid_o(op_valid),
        .arith_o(op_arith)
    );

    assign set_bit = sum_v[MSB];

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_sl
        logic cin_w;
        logic cout_w;
        logic less_w;

        if (gi == 0) begin : g_first
            assign cin_w  = inv;
            assign less_w = set_bit;
        end else begin : g_rest
            assign cin_w  = g_sl[gi-1].cout_w;
            assign less_w = 1'b0;
        end

        alu_bit_slice u_slice (
            .a_i   (a_in[gi]),
            .b_i   (b_in[gi]),
            .inv_i (inv),
            .cin_i (cin_w),
            .less_i(less_w),
            .sel_i (sel),
            .res_o (res_v[gi]),
            .sum_o (sum_v[gi]),
            .cout_o(cout_w)
        );
    end

    assign msb_cin  = g_sl[MSB].cin_w;
    assign msb_cout = g_sl[MSB].cout_w;

    assign result_o = op_valid ? res_v : '0;
    assign ovf_o    = op_arith & (msb_cin ^ msb_cout);

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word_i(result_o),
        .zero_o(zero_o)
    );

endmodule

// File: rtl/bitslice_alu_chk.sv
module bitslice_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [2:0]       op_in,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             ovf_o
);

    logic known;
    assign known = !$isunknown({a_in, b_in, op_in, result_o, zero_o, ovf_o});

    always_comb begin
        if (known) begin
            // R6
            zero_flag_chk: assert (zero_o == (result_o == '0))
                else $error("zero flag disagrees with result");
            // R9
            no_overflow_chk: assert (!((op_in == 3'b000 || op_in == 3'b001 || op_in == 3'b111) && ovf_o))
                else $error("overflow raised on non-arithmetic op");
            // R5
            slt_upper_chk: assert (op_in != 3'b111 || result_o[WIDTH-1:1] == '0)
                else $error("set-less-than upper bits not clear");
            // R10
            undef_op_chk: assert (!(op_in == 3'b011 || op_in == 3'b100 || op_in == 3'b101)
                                  || (result_o == '0 && !ovf_o))
                else $error("undefined op produced output");
            // R1
            and_op_chk: assert (op_in != 3'b000 || result_o == (a_in & b_in))
                else $error("AND result mismatch");
        end
    end

endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_in    (a_in),
    .b_in    (b_in),
    .op_in   (op_in),
    .result_o(result_o),
    .zero_o  (zero_o),
    .ovf_o   (ovf_o)
);

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb_top;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic [2:0]   op;
    logic [W-1:0] res;
    logic         zf, of;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bitslice_alu #(.WIDTH(W)) dut_i (
        .a_in    (a),
        .b_in    (b),
        .op_in   (op),
        .result_o(res),
        .zero_o  (zf),
        .ovf_o   (of)
    );

    task automatic check(input string req, input logic [W-1:0] er,
                         input logic ez, input logic eo);
        n_chk++;
        if (res !== er || zf !== ez || of !== eo) begin
            n_bad++;
            $display("FAIL %s op=%b a=%h b=%h: got res=%h z=%b o=%b exp res=%h z=%b o=%b",
                     req, op, a, b, res, zf, of, er, ez, eo);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        op = o; a = x; b = y;
        @(negedge clk);
    endtask

    // R1
    task automatic t_and();
        apply(3'b000, 32'hF0F0_F0F0, 32'hFF00_FF00);
        check("R1", 32'hF000_F000, 1'b0, 1'b0);
        apply(3'b000, 32'hAAAA_AAAA, 32'h5555_5555);
        check("R1/R6", 32'h0, 1'b1, 1'b0);
    endtask

    // R2
    task automatic t_or();
        apply(3'b001, 32'hF0F0_F0F0, 32'hFF00_FF00);
        check("R2", 32'hFFF0_FFF0, 1'b0, 1'b0);
        apply(3'b001, 32'h0, 32'h0);
        check("R2/R6", 32'h0, 1'b1, 1'b0);
    endtask

    // R3, R7
    task automatic t_add();
        apply(3'b010, 32'd1234, 32'd4321);
        check("R3", 32'd5555, 1'b0, 1'b0);
        apply(3'b010, 32'hFFFF_FFFF, 32'h1);
        check("R3/R6", 32'h0, 1'b1, 1'b0);
        apply(3'b010, 32'h7FFF_FFFF, 32'h1);
        check("R7 pos+pos", 32'h8000_0000, 1'b0, 1'b1);
        apply(3'b010, 32'h8000_0000, 32'h8000_0000);
        check("R7 neg+neg", 32'h0, 1'b1, 1'b1);
        apply(3'b010, 32'h7FFF_FFFF, 32'h8000_0000);
        check("R7 mixed", 32'hFFFF_FFFF, 1'b0, 1'b0);
    endtask

    // R4, R8
    task automatic t_sub();
        apply(3'b110, 32'd100, 32'd58);
        check("R4", 32'd42, 1'b0, 1'b0);
        apply(3'b110, 32'd7, 32'd7);
        check("R4/R6 equal", 32'h0, 1'b1, 1'b0);
        apply(3'b110, 32'd2, 32'd5);
        check("R4 negative", 32'hFFFF_FFFD, 1'b0, 1'b0);
        apply(3'b110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        check("R8 pos-neg", 32'h8000_0000, 1'b0, 1'b1);
        apply(3'b110, 32'h8000_0000, 32'h1);
        check("R8 neg-pos", 32'h7FFF_FFFF, 1'b0, 1'b1);
        apply(3'b110, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R8 same sign", 32'h0, 1'b1, 1'b0);
    endtask

    // R5, R9
    task automatic t_slt();
        apply(3'b111, 32'hFFFF_FFFE, 32'd3);
        check("R5 neg<pos", 32'h1, 1'b0, 1'b0);
        apply(3'b111, 32'd9, 32'd4);
        check("R5 greater", 32'h0, 1'b1, 1'b0);
        apply(3'b111, 32'd4, 32'd4);
        check("R5 equal", 32'h0, 1'b1, 1'b0);
        apply(3'b111, 32'h7FFF_FFFF, 32'h8000_0000);
        check("R5/R9 raw sign", 32'h1, 1'b0, 1'b0);
        apply(3'b001, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        check("R9 or", 32'h7FFF_FFFF, 1'b0, 1'b0);
    endtask

    // R10
    task automatic t_undef();
        for (int k = 0; k < 3; k++) begin
            logic [2:0] c;
            c = (k == 0) ? 3'b011 : (k == 1) ? 3'b100 : 3'b101;
            apply(c, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
            check("R10", 32'h0, 1'b1, 1'b0);
        end
    endtask

    initial begin
        a = '0; b = '0; op = 3'b000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1/R6 reset", 32'h0, 1'b1, 1'b0);
        t_and();
        t_or();
        t_add();
        t_sub();
        t_slt();
        t_undef();
        done = 1'b1;
    end

    initial begin
        for (int cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
        end
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule